// File: doc/BRIEF.md
# Pointer-Masking Control Register Bank

This block is a bank of pointer-masking configuration registers that sits behind the CSR unit of a core with privilege levels. It decodes a 12-bit CSR address and serves reads and writes. There is one physical control word. The machine, supervisor and user levels each see a different masked view of it. Each level also has its own full-width mask register and base register. These are driven on dedicated outputs to the address-masking datapath, which lives outside this block.

The block enforces the legal fields of each view and the bits that are hardwired. It also applies a privilege rule: a level writing its own registers has the write silently discarded unless that level's "current" bit is set. Every write that takes effect marks the extension state dirty. It also emits a one-cycle request to set the extension-state and summary-dirty bits of the status register. Any access while the extension is disabled raises an illegal-instruction indication.

Top module: `pmc_bank`

## Requirements
- R1: The block decodes nine addresses. Address bits [9:8] give the level: 3 is machine, 1 is supervisor, 0 is user. The group values are 0x3, 0x1 and 0x4 in bits [11:8]. The low byte selects the register: 0xC0 is the control view, 0xC1 is the mask and 0xC2 is the base. Read data is valid in the cycle after csr_re.
- R2: After reset, the control word reads 0x201 through the machine view. That is state field 1 (initial) with the machine current bit set. All masks and bases are zero.
- R3: Control word fields. The state field is bits [1:0], encoded 0 disabled, 1 initial, 2 clean, 3 dirty. User enable, current and instruction are bits 2, 3 and 4. Supervisor enable, current and instruction are bits 5, 6 and 7. Machine enable, current and instruction are bits 8, 9 and 10. Bits above 10 read zero.
- R4: The three views expose different bits. The machine view exposes bits [10:0] (mask 0x7FF). The supervisor view exposes bits [7:0] (0x0FF). The user view exposes bits [4:2] (0x01C). A view write leaves the bits outside its mask unchanged, and those bits read as zero through that view.
- R5: Every control-word write that takes effect forces bit 9 to 1, forces bits 4, 7 and 10 to 0, and sets the state field to 3.
- R6: A mask or base write that takes effect stores the whole data word and sets the state field to 3.
- R7: status_dirty_set is high for exactly one cycle, the cycle after each write that takes effect. It stays low for dropped, illegal or undecoded writes.
- R8: The write is dropped when priv equals the level of the addressed register and that level's current bit is 0. No state changes and no fault is raised.
- R9: Machine-level control, mask and base writes always take effect while the extension is enabled.
- R10: When ext_en is 0, any read or write to a decoded address sets illegal in the next cycle and returns zero read data. The access changes no state.
- R11: An undecoded address returns zero read data, keeps illegal low and changes no state.
- R12: Priv is encoded as 0 user, 1 supervisor and 3 machine. Priv value 2 matches no level, so it never causes a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_re | input | 1 | Read strobe |
| priv | input | 2 | Current privilege level |
| ext_en | input | 1 | Pointer-masking extension enabled |
| csr_rdata | output | XLEN | Registered read data |
| illegal | output | 1 | Registered illegal-instruction indication |
| status_dirty_set | output | 1 | One-cycle request to set the status XS and SD bits |
| m_mask | output | XLEN | Machine-level mask |
| m_base | output | XLEN | Machine-level base |
| s_mask | output | XLEN | Supervisor-level mask |
| s_base | output | XLEN | Supervisor-level base |
| u_mask | output | XLEN | User-level mask |
| u_base | output | XLEN | User-level base |

## Verification
Every result is due one clock edge after its stimulus. A write updates the stored registers and the level outputs, and raises status_dirty_set, on the edge that samples it. csr_rdata and illegal appear on the edge that samples the read. The bench drives each access just after an edge and samples the outputs just after the next edge. The stored state is then re-read through the read port on the following access. This keeps every check one register stage from its cause.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int CW = 11;

  localparam int U_EN  = 2;
  localparam int U_CUR = 3;
  localparam int U_INS = 4;
  localparam int S_EN  = 5;
  localparam int S_CUR = 6;
  localparam int S_INS = 7;
  localparam int M_EN  = 8;
  localparam int M_CUR = 9;
  localparam int M_INS = 10;

  localparam logic [1:0] ST_INIT  = 2'd1;
  localparam logic [1:0] ST_DIRTY = 2'd3;

  localparam logic [CW-1:0] CTRL_RST = CW'(11'h201);

  typedef enum logic [1:0] {
    LVL_U = 2'd0,
    LVL_S = 2'd1,
    LVL_R = 2'd2,
    LVL_M = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    K_CTRL = 2'd0,
    K_MASK = 2'd1,
    K_BASE = 2'd2,
    K_NONE = 2'd3
  } kind_e;

  function automatic logic [CW-1:0] view_mask(lvl_e l);
    case (l)
      LVL_M:   return CW'(11'h7FF);
      LVL_S:   return CW'(11'h0FF);
      LVL_U:   return CW'(11'h01C);
      default: return '0;
    endcase
  endfunction

  function automatic int cur_bit(lvl_e l);
    case (l)
      LVL_U:   return U_CUR;
      LVL_S:   return S_CUR;
      default: return M_CUR;
    endcase
  endfunction
endpackage

// File: rtl/pmc_decode.sv
module pmc_decode
  import pmc_pkg::*;
(
  input  logic [11:0] addr,
  output logic        hit,
  output lvl_e        lvl,
  output kind_e       kind
);
  logic grp_ok;
  logic off_ok;

  always_comb begin
    grp_ok = (addr[11:8] == 4'h3) || (addr[11:8] == 4'h1) || (addr[11:8] == 4'h4);
    off_ok = (addr[7:2] == 6'b110000) && (addr[1:0] != 2'b11);
    hit    = grp_ok && off_ok;
    lvl    = lvl_e'(addr[9:8]);
    kind   = hit ? kind_e'(addr[1:0]) : K_NONE;
  end
endmodule

// File: rtl/pmc_ctrl_word.sv
module pmc_ctrl_word
  import pmc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          touch,
  input  lvl_e          view,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] ctrl_q
);
  logic [CW-1:0] vm;
  logic [CW-1:0] nxt;

  always_comb begin
    vm  = view_mask(view);
    nxt = ctrl_q;
    if (we) begin
      nxt        = (wdata & vm) | (ctrl_q & ~vm);
      nxt[U_INS] = 1'b0;
      nxt[S_INS] = 1'b0;
      nxt[M_INS] = 1'b0;
      nxt[M_CUR] = 1'b1;
      nxt[1:0]   = ST_DIRTY;
    end else if (touch) begin
      nxt[1:0]   = ST_DIRTY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_RST;
    else     ctrl_q <= nxt;
  end

  // R5
  ctrl_force_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (ctrl_q[M_CUR] && !ctrl_q[U_INS] && !ctrl_q[S_INS] && !ctrl_q[M_INS]
            && ctrl_q[1:0] == ST_DIRTY));

  // R6
  touch_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    touch |=> (ctrl_q[1:0] == ST_DIRTY));

  // R4
  view_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (we && view == LVL_U) |=> (ctrl_q[M_EN] == $past(ctrl_q[M_EN])
                               && ctrl_q[S_EN] == $past(ctrl_q[S_EN])));
endmodule

// File: rtl/pmc_level_regs.sv
module pmc_level_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_mask,
  input  logic         we_base,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      base_q <= '0;
    end else begin
      if (we_mask) mask_q <= wdata;
      if (we_base) base_q <= wdata;
    end
  end

  // R6
  mask_store_chk: assert property (@(posedge clk) disable iff (rst)
    we_mask |=> (mask_q == $past(wdata)));

  // R1
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    !(we_mask && we_base));
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [11:0]     csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            csr_re,
  input  logic [1:0]      priv,
  input  logic            ext_en,
  output logic [XLEN-1:0] csr_rdata,
  output logic            illegal,
  output logic            status_dirty_set,
  output logic [XLEN-1:0] m_mask,
  output logic [XLEN-1:0] m_base,
  output logic [XLEN-1:0] s_mask,
  output logic [XLEN-1:0] s_base,
  output logic [XLEN-1:0] u_mask,
  output logic [XLEN-1:0] u_base
);
  localparam int NLVL = 3;

  logic          hit;
  lvl_e          lvl;
  kind_e         kind;
  logic [CW-1:0] ctrl_q;
  logic          blocked;
  logic          commit;
  logic [1:0]    slot;
  logic [XLEN-1:0] rd_mux;
  logic [XLEN-1:0] mask_a [NLVL];
  logic [XLEN-1:0] base_a [NLVL];

  pmc_decode u_dec (
    .addr (csr_addr),
    .hit  (hit),
    .lvl  (lvl),
    .kind (kind)
  );

  always_comb begin
    blocked = (priv == lvl) && !ctrl_q[cur_bit(lvl)];
    commit  = csr_we && hit && ext_en && !blocked;
    case (lvl)
      LVL_M:   slot = 2'd2;
      LVL_S:   slot = 2'd1;
      default: slot = 2'd0;
    endcase
  end

  pmc_ctrl_word u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .we     (commit && kind == K_CTRL),
    .touch  (commit && (kind == K_MASK || kind == K_BASE)),
    .view   (lvl),
    .wdata  (csr_wdata[CW-1:0]),
    .ctrl_q (ctrl_q)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    pmc_level_regs #(.W(XLEN)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .we_mask (commit && kind == K_MASK && slot == 2'(g)),
      .we_base (commit && kind == K_BASE && slot == 2'(g)),
      .wdata   (csr_wdata),
      .mask_q  (mask_a[g]),
      .base_q  (base_a[g])
    );
  end

  assign u_mask = mask_a[0];
  assign u_base = base_a[0];
  assign s_mask = mask_a[1];
  assign s_base = base_a[1];
  assign m_mask = mask_a[2];
  assign m_base = base_a[2];

  always_comb begin
    rd_mux = '0;
    case (kind)
      K_CTRL: rd_mux = XLEN'(ctrl_q & view_mask(lvl));
      K_MASK: rd_mux = (lvl == LVL_M) ? mask_a[2] : (lvl == LVL_S) ? mask_a[1] : mask_a[0];
      K_BASE: rd_mux = (lvl == LVL_M) ? base_a[2] : (lvl == LVL_S) ? base_a[1] : base_a[0];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata        <= '0;
      illegal          <= 1'b0;
      status_dirty_set <= 1'b0;
    end else begin
      csr_rdata        <= (csr_re && hit && ext_en) ? rd_mux : '0;
      illegal          <= (csr_re || csr_we) && hit && !ext_en;
      status_dirty_set <= commit;
    end
  end

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (csr_rdata == '0 && !status_dirty_set));

  // R8
  user_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_we && ext_en && csr_addr == 12'h4C1 && priv == 2'd0 && !ctrl_q[U_CUR])
      |=> ($stable(u_mask) && !status_dirty_set));

  // R9
  mach_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_we && ext_en && csr_addr == 12'h3C1)
      |=> (status_dirty_set && m_mask == $past(csr_wdata)));

  // R11
  miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((csr_re || csr_we) && !hit) |=> (!illegal && csr_rdata == '0 && !status_dirty_set));
endmodule

// File: tb/pmc_bank_test.sv
module pmc_bank_test;
  localparam int CLK_P = 10;
  localparam int XL = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [11:0]   csr_addr = '0;
  logic          csr_we = 1'b0;
  logic [XL-1:0] csr_wdata = '0;
  logic          csr_re = 1'b0;
  logic [1:0]    priv = 2'd3;
  logic          ext_en = 1'b1;
  logic [XL-1:0] csr_rdata;
  logic          illegal;
  logic          status_dirty_set;
  logic [XL-1:0] m_mask, m_base, s_mask, s_base, u_mask, u_base;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [10:0]   mc;
  logic [XL-1:0] mm [3];
  logic [XL-1:0] mb [3];

  always #(CLK_P/2) clk = ~clk;

  pmc_bank #(.XLEN(XL)) uut (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_re(csr_re), .priv(priv), .ext_en(ext_en),
    .csr_rdata(csr_rdata), .illegal(illegal), .status_dirty_set(status_dirty_set),
    .m_mask(m_mask), .m_base(m_base), .s_mask(s_mask), .s_base(s_base),
    .u_mask(u_mask), .u_base(u_base)
  );

  task automatic chk(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R1: group values 3/1/4 in bits [11:8], offsets C0..C2
  function automatic bit b_hit(logic [11:0] a);
    return (a[11:8] == 4'h3 || a[11:8] == 4'h1 || a[11:8] == 4'h4)
           && a[7:0] >= 8'hC0 && a[7:0] <= 8'hC2;
  endfunction

  function automatic int b_idx(logic [11:0] a);
    if (a[9:8] == 2'd3) return 2;
    if (a[9:8] == 2'd1) return 1;
    return 0;
  endfunction

  // R4 view masks
  function automatic logic [10:0] b_vm(int i);
    if (i == 2) return 11'h7FF;
    if (i == 1) return 11'h0FF;
    return 11'h01C;
  endfunction

  // R3 current bit positions, R12 priv codes
  function automatic int b_cur(int i);
    if (i == 2) return 9;
    if (i == 1) return 6;
    return 3;
  endfunction

  function automatic logic [1:0] b_pcode(int i);
    if (i == 2) return 2'd3;
    return 2'(i);
  endfunction

  function automatic logic [11:0] addr_of(int j);
    logic [11:0] b;
    b = (j / 3 == 0) ? 12'h3C0 : (j / 3 == 1) ? 12'h1C0 : 12'h4C0;
    return b + 12'(j % 3);
  endfunction

  function automatic logic [XL-1:0] exp_rd(logic [11:0] a);
    int i;
    if (!ext_en || !b_hit(a)) return '0;
    i = b_idx(a);
    case (a[1:0])
      2'd0:    return XL'(mc & b_vm(i));
      2'd1:    return mm[i];
      default: return mb[i];
    endcase
  endfunction

  task automatic wr(input logic [11:0] a, input logic [1:0] p, input logic [XL-1:0] d);
    int i;
    bit commit;
    logic [10:0] vm;
    string tag;
    i = b_idx(a);
    commit = ext_en && b_hit(a) && !(b_pcode(i) == p && !mc[b_cur(i)]);
    if (!b_hit(a)) tag = "R11";
    else if (!ext_en) tag = "R10";
    else if (!commit) tag = "R8";
    else if (i == 2) tag = "R9";
    else tag = "R7";
    csr_addr = a; priv = p; csr_wdata = d; csr_we = 1'b1; csr_re = 1'b0;
    @(posedge clk); #1;
    csr_we = 1'b0;
    chk({tag, " dirty pulse"}, XL'(status_dirty_set), XL'(commit));
    chk({tag, " illegal"}, XL'(illegal), XL'(b_hit(a) && !ext_en));
    if (commit) begin
      vm = b_vm(i);
      case (a[1:0])
        2'd0: begin
          mc = (d[10:0] & vm) | (mc & ~vm);
          mc[9] = 1'b1; mc[4] = 1'b0; mc[7] = 1'b0; mc[10] = 1'b0;
          mc[1:0] = 2'd3;
        end
        2'd1: begin mm[i] = d; mc[1:0] = 2'd3; end
        default: begin mb[i] = d; mc[1:0] = 2'd3; end
      endcase
    end
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    logic [XL-1:0] e;
    e = exp_rd(a);
    csr_addr = a; csr_re = 1'b1; csr_we = 1'b0;
    @(posedge clk); #1;
    csr_re = 1'b0;
    chk({tag, " rdata"}, csr_rdata, e);
    chk({tag, " illegal"}, XL'(illegal), XL'(b_hit(a) && !ext_en));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mc = 11'h201;
    for (int i = 0; i < 3; i++) begin mm[i] = '0; mb[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R2 reset state
    rd(12'h3C0, "R2");
    chk("R2 ctrl value", csr_rdata, 32'h201);
    chk("R2 outputs", m_mask | m_base | s_mask | s_base | u_mask | u_base, '0);
    chk("R7 no pulse at reset", XL'(status_dirty_set), '0);

    // R1 R3 R4 R5 R6 R8 R9 R12 sweep over control patterns, privs and addresses
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 4; p++) begin
        for (int j = 0; j < 9; j++) begin
          logic [XL-1:0] d;
          d = 32'h9E37_79B9 * 32'(c * 40 + p * 10 + j + 1);
          wr(12'h3C0, 2'd3, XL'((c & 1) << 3) | XL'(((c >> 1) & 1) << 6)
                           | XL'(((c >> 2) & 1) << 2) | XL'(((c >> 2) & 1) << 5));
          wr(addr_of(j), 2'(p), d);
          for (int k = 0; k < 9; k++) begin
            rd(addr_of(k), (k % 3 == 0) ? "R4" : "R6");
          end
        end
      end
    end
    chk("R1 m_mask port", m_mask, mm[2]);
    chk("R1 s_base port", s_base, mb[1]);
    chk("R1 u_mask port", u_mask, mm[0]);

    // R10 extension disabled
    ext_en = 1'b0;
    wr(12'h3C1, 2'd3, 32'hDEAD_BEEF);
    rd(12'h1C2, "R10");
    wr(12'h4C0, 2'd3, 32'hFFFF_FFFF);
    ext_en = 1'b1;
    rd(12'h3C1, "R10");
    rd(12'h4C0, "R10");

    // R11 undecoded addresses
    wr(12'h3C3, 2'd3, 32'h1234_5678);
    wr(12'h0C1, 2'd3, 32'h1234_5678);
    wr(12'h5C1, 2'd3, 32'h1234_5678);
    wr(12'h3C4, 2'd3, 32'h1234_5678);
    rd(12'h3C3, "R11");
    rd(12'h2C0, "R11");
    rd(12'h3C1, "R11");
    rd(12'h3C0, "R11");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule